// File: doc/BRIEF.md
# Combo PHY Bring-Up Sequencer

This block is a hardware state machine that takes a combined USB / DisplayPort PHY from full reset to an operating state. A one-cycle start pulse captures three configuration inputs: USB mode, DP mode and plug orientation (flip). The sequencer then works through a fixed list of steps. It drives a receive-LFPS enable, a PMA power enable and five reset lines, which are init, common, lane, PCS-APB and PMA-APB. It streams two tables of configuration writes over a simple register bus, and it programs the lane-mux register with a read-modify-write. It releases the remaining resets in stages and then polls the PLL and clock-recovery status.

The tables come from a parameterised ROM. Each ROM entry holds an address, a data byte and an optional pause that must pass before the next write. A failure during the table writes or a PLL timeout unwinds the released resets in groups and raises `error`. A clock-recovery timeout only sets a warning bit, and the sequence still completes. The bus is single-cycle. Read data and the write-error flag are sampled in the same cycle as the strobe.

Top module: `phy_bringup_seq`

## Requirements
- R1: When USB mode is captured, `lfps_en` is high before `pma_pwr_en` rises. In DP-only mode `lfps_en` stays low.
- R2: `pma_pwr_en` rises first. `rst_pmaapb` falls next, then `rst_pcsapb`. No bus write happens while either APB reset is asserted.
- R3: The table writes come first and there are N_INIT+N_REF of them. Entry k (k = 0 .. N_INIT-1) is written to INIT_BASE+4k. Entry k (k = N_INIT .. N_INIT+N_REF-1) is written to REF_BASE+4(k-N_INIT). Each entry carries the data byte (37k+5) mod 256, zero-extended to DATA_W.
- R4: An entry with k mod 5 = 3 carries a pause of TBL_GAP cycles, so the next write comes exactly 1+TBL_GAP cycles later. All other entries are written back to back, one cycle apart.
- R5: After the tables, the block reads MUX_ADDR and then writes MUX_ADDR back. The written value has these fields:
  - bits [DATA_W-1:8] are kept from the read.
  - bits [7:4] are the DP lane enables and are cleared.
  - bits [3:0] hold one bit per lane, where 1 means DP. The lane bits are 1111 in DP-only mode and 0000 in USB-only mode. With both modes they are 1100 when not flipped and 0011 when flipped.
- R6: After the mux write, `rst_init` falls only in USB mode. In DP mode a single write of 1 to DPRST_ADDR follows the mux write.
- R7: `rst_cmn` falls at least SETTLE_CYC cycles after the init step, and `rst_lane` falls after it. Both fall only in USB mode. DP-only mode ends with `done` after the settle time, and `rst_init`, `rst_cmn` and `rst_lane` stay asserted.
- R8: In USB mode the block reads PLL_ADDR until bits [1:0] are both 1. The reads are spaced POLL_GAP+1 cycles apart, and there are at most POLL_TRIES of them.
- R9: After the PLL locks, the block polls CDR0_ADDR when not flipped, or CDR2_ADDR when flipped, until bit 0 is 1. If POLL_TRIES reads go by without lock, the block sets `cdr_warn` and `done` with `error` low, and leaves all resets released.
- R10: On a PLL timeout, `rst_init`, `rst_cmn` and `rst_lane` rise together. One cycle later `rst_pcsapb` and `rst_pmaapb` rise, and `done` and `error` are set. `error` is never high without `done`.
- R11: `bus_err` high during a table write stops all further bus writes. Only the two APB resets are re-asserted, the init, common and lane resets stay asserted, and `done` and `error` are set.
- R12: After reset, all five reset outputs are high. `lfps_en`, `pma_pwr_en`, `done`, `error`, `cdr_warn`, `bus_wr` and `bus_rd` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle pulse that starts a bring-up; accepted only while idle |
| mode_usb | input | 1 | USB mode, captured at start |
| mode_dp | input | 1 | DP mode, captured at start |
| flip | input | 1 | Plug orientation, captured at start |
| lfps_en | output | 1 | Receive-LFPS enable |
| pma_pwr_en | output | 1 | PMA power enable |
| rst_init | output | 1 | Init reset, 1 = asserted |
| rst_cmn | output | 1 | Common reset, 1 = asserted |
| rst_lane | output | 1 | Lane reset, 1 = asserted |
| rst_pcsapb | output | 1 | PCS register-port reset, 1 = asserted |
| rst_pmaapb | output | 1 | PMA register-port reset, 1 = asserted |
| bus_wr | output | 1 | Write strobe |
| bus_rd | output | 1 | Read strobe |
| bus_addr | output | ADDR_W | Register address |
| bus_wdata | output | DATA_W | Write data |
| bus_rdata | input | DATA_W | Read data, valid in the cycle of `bus_rd` |
| bus_err | input | 1 | Write failure, valid in the cycle of `bus_wr` |
| done | output | 1 | Sequence finished; cleared by the next start |
| error | output | 1 | Sequence aborted |
| cdr_warn | output | 1 | Clock-recovery lock timed out |

## Verification
The assertions check the following ordering rules on every cycle:
- LFPS is enabled ahead of power.
- Power comes up before the APB releases, and PMA-APB is released before PCS-APB.
- No write is made while an APB reset is held.
- The common reset is released only after the init reset, with the settle time measured by a counter, and the lane reset follows the common reset.
- Any rise of the APB resets finds the three core resets already raised.
- `error` never appears without `done`.

Only the bench scenarios can show the data-dependent behaviour:
- the exact table addresses, data and pauses;
- the lane-mux value for each mode and orientation;
- the choice of lane for the clock-recovery poll;
- the number and spacing of the poll reads;
- the two different unwinds after a PLL timeout and after a table write failure.

// File: rtl/phy_bringup_pkg.sv
package phy_bringup_pkg;

  typedef enum logic [4:0] {
    ST_IDLE, ST_PWR, ST_APB_PMA, ST_APB_PCS, ST_TBL_WR, ST_TBL_DLY,
    ST_MUX_RD, ST_MUX_WR, ST_RST_INIT, ST_SETTLE, ST_REL_CMN, ST_REL_LANE,
    ST_PLL_RD, ST_PLL_GAP, ST_CDR_RD, ST_CDR_GAP, ST_UNW_PHY, ST_UNW_APB
  } seq_st_e;

  typedef struct packed {
    logic [15:0] addr;
    logic [7:0]  data;
    logic [3:0]  dly;
  } tbl_ent_t;

  // Configuration ROM content for entry k: init table first, then refclk table.
  function automatic tbl_ent_t tbl_entry(input int k, input int n_init,
                                         input int init_base, input int ref_base,
                                         input int gap);
    tbl_ent_t e;
    int j;
    j = (k < n_init) ? k : k - n_init;
    e.addr = 16'(((k < n_init) ? init_base : ref_base) + 4 * j);
    e.data = 8'((37 * k + 5) % 256);
    e.dly  = ((k % 5) == 3) ? 4'(gap) : 4'd0;
    return e;
  endfunction

  // Lane owner bits, 1 = DP, indexed by PHY lane.
  function automatic logic [3:0] lane_map(input logic usb, input logic dp,
                                          input logic flp);
    if (!dp) return 4'b0000;
    if (!usb) return 4'b1111;
    return flp ? 4'b0011 : 4'b1100;
  endfunction

endpackage

// File: rtl/phy_cfg_rom.sv
module phy_cfg_rom
  import phy_bringup_pkg::*;
#(
  parameter int N_INIT    = 6,
  parameter int N_REF     = 5,
  parameter int INIT_BASE = 'h100,
  parameter int REF_BASE  = 'h300,
  parameter int GAP_CYC   = 3,
  parameter int ADDR_W    = 16,
  parameter int IDX_W     = 4
) (
  input  logic [IDX_W-1:0]  idx,
  output logic [ADDR_W-1:0] addr,
  output logic [7:0]        data,
  output logic [3:0]        dly,
  output logic              last
);
  localparam int N_ENT = N_INIT + N_REF;

  tbl_ent_t rom [N_ENT];
  tbl_ent_t ent;

  for (genvar k = 0; k < N_ENT; k++) begin : g_ent
    assign rom[k] = tbl_entry(k, N_INIT, INIT_BASE, REF_BASE, GAP_CYC);
  end

  assign ent  = rom[idx];
  assign addr = ent.addr[ADDR_W-1:0];
  assign data = ent.data;
  assign dly  = ent.dly;
  assign last = (idx == IDX_W'(N_ENT - 1));
endmodule

// File: rtl/phy_wait_timer.sv
module phy_wait_timer #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] val,
  output logic         expire
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load)           cnt_q <= val;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  // high in the last of the loaded number of waiting cycles
  assign expire = (cnt_q == W'(1));
endmodule

// File: rtl/phy_bringup_seq.sv
module phy_bringup_seq
  import phy_bringup_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 16,
  parameter int N_INIT     = 6,
  parameter int N_REF      = 5,
  parameter int INIT_BASE  = 'h100,
  parameter int REF_BASE   = 'h300,
  parameter int TBL_GAP    = 3,
  parameter int MUX_ADDR   = 'h0A0,
  parameter int DPRST_ADDR = 'h0A4,
  parameter int PLL_ADDR   = 'h0B0,
  parameter int CDR0_ADDR  = 'h0C0,
  parameter int CDR2_ADDR  = 'h0C8,
  parameter int SETTLE_CYC = 20,
  parameter int POLL_GAP   = 8,
  parameter int POLL_TRIES = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              mode_usb,
  input  logic              mode_dp,
  input  logic              flip,
  output logic              lfps_en,
  output logic              pma_pwr_en,
  output logic              rst_init,
  output logic              rst_cmn,
  output logic              rst_lane,
  output logic              rst_pcsapb,
  output logic              rst_pmaapb,
  output logic              bus_wr,
  output logic              bus_rd,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              bus_err,
  output logic              done,
  output logic              error,
  output logic              cdr_warn
);
  localparam int N_ENT   = N_INIT + N_REF;
  localparam int IDX_W   = (N_ENT > 1) ? $clog2(N_ENT) : 1;
  localparam int TMR_MAX = (SETTLE_CYC > POLL_GAP) ? ((SETTLE_CYC > 15) ? SETTLE_CYC : 15)
                                                   : ((POLL_GAP > 15) ? POLL_GAP : 15);
  localparam int TMR_W   = $clog2(TMR_MAX + 1);
  localparam int TRY_W   = (POLL_TRIES > 1) ? $clog2(POLL_TRIES) : 1;
  localparam logic [DATA_W-1:0] MUX_KEEP = ~DATA_W'(8'hFF);

  seq_st_e           st_q;
  logic [IDX_W-1:0]  idx_q;
  logic [TRY_W-1:0]  tries_q;
  logic              usb_q, dp_q, flip_q;
  logic [DATA_W-1:0] mux_q;

  logic [ADDR_W-1:0] ent_addr;
  logic [7:0]        ent_data;
  logic [3:0]        ent_dly;
  logic              tbl_last;
  logic              tmr_load;
  logic [TMR_W-1:0]  tmr_val;
  logic              tmr_expire;

  // named internal events
  wire tbl_has_gap = (ent_dly != 4'd0);
  wire pll_ok      = (bus_rdata[1:0] == 2'b11);
  wire cdr_ok      = bus_rdata[0];
  wire poll_out    = (tries_q == TRY_W'(POLL_TRIES - 1));
  wire [ADDR_W-1:0] cdr_addr = flip_q ? ADDR_W'(CDR2_ADDR) : ADDR_W'(CDR0_ADDR);

  phy_cfg_rom #(
    .N_INIT(N_INIT), .N_REF(N_REF), .INIT_BASE(INIT_BASE), .REF_BASE(REF_BASE),
    .GAP_CYC(TBL_GAP), .ADDR_W(ADDR_W), .IDX_W(IDX_W)
  ) u_rom (
    .idx(idx_q), .addr(ent_addr), .data(ent_data), .dly(ent_dly), .last(tbl_last)
  );

  phy_wait_timer #(.W(TMR_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .val(tmr_val), .expire(tmr_expire)
  );

  always_comb begin
    bus_wr    = 1'b0;
    bus_rd    = 1'b0;
    bus_addr  = '0;
    bus_wdata = '0;
    case (st_q)
      ST_TBL_WR: begin
        bus_wr = 1'b1; bus_addr = ent_addr; bus_wdata = DATA_W'(ent_data);
      end
      ST_MUX_RD: begin
        bus_rd = 1'b1; bus_addr = ADDR_W'(MUX_ADDR);
      end
      ST_MUX_WR: begin
        bus_wr = 1'b1; bus_addr = ADDR_W'(MUX_ADDR);
        bus_wdata = (mux_q & MUX_KEEP) | DATA_W'(lane_map(usb_q, dp_q, flip_q));
      end
      ST_RST_INIT: if (dp_q) begin
        bus_wr = 1'b1; bus_addr = ADDR_W'(DPRST_ADDR); bus_wdata = DATA_W'(1);
      end
      ST_PLL_RD: begin
        bus_rd = 1'b1; bus_addr = ADDR_W'(PLL_ADDR);
      end
      ST_CDR_RD: begin
        bus_rd = 1'b1; bus_addr = cdr_addr;
      end
      default: ;
    endcase
  end

  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = '0;
    case (st_q)
      ST_TBL_WR:   if (!bus_err && tbl_has_gap) begin
        tmr_load = 1'b1; tmr_val = TMR_W'(ent_dly);
      end
      ST_RST_INIT: begin
        tmr_load = 1'b1; tmr_val = TMR_W'(SETTLE_CYC);
      end
      ST_PLL_RD:   if (!pll_ok && !poll_out) begin
        tmr_load = 1'b1; tmr_val = TMR_W'(POLL_GAP);
      end
      ST_CDR_RD:   if (!cdr_ok && !poll_out) begin
        tmr_load = 1'b1; tmr_val = TMR_W'(POLL_GAP);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE; idx_q <= '0; tries_q <= '0; mux_q <= '0;
      usb_q <= 1'b0; dp_q <= 1'b0; flip_q <= 1'b0;
      lfps_en <= 1'b0; pma_pwr_en <= 1'b0;
      rst_init <= 1'b1; rst_cmn <= 1'b1; rst_lane <= 1'b1;
      rst_pcsapb <= 1'b1; rst_pmaapb <= 1'b1;
      done <= 1'b0; error <= 1'b0; cdr_warn <= 1'b0;
    end else begin
      case (st_q)
        ST_IDLE: if (start) begin
          usb_q <= mode_usb; dp_q <= mode_dp; flip_q <= flip;
          lfps_en <= mode_usb; pma_pwr_en <= 1'b0;
          rst_init <= 1'b1; rst_cmn <= 1'b1; rst_lane <= 1'b1;
          rst_pcsapb <= 1'b1; rst_pmaapb <= 1'b1;
          done <= 1'b0; error <= 1'b0; cdr_warn <= 1'b0;
          idx_q <= '0;
          st_q <= ST_PWR;
        end
        ST_PWR:     begin pma_pwr_en <= 1'b1; st_q <= ST_APB_PMA; end
        ST_APB_PMA: begin rst_pmaapb <= 1'b0; st_q <= ST_APB_PCS; end
        ST_APB_PCS: begin rst_pcsapb <= 1'b0; st_q <= ST_TBL_WR; end
        ST_TBL_WR: begin
          if (bus_err)          st_q <= ST_UNW_APB;
          else if (tbl_has_gap) st_q <= ST_TBL_DLY;
          else if (tbl_last)    st_q <= ST_MUX_RD;
          else                  idx_q <= idx_q + 1'b1;
        end
        ST_TBL_DLY: if (tmr_expire) begin
          if (tbl_last) st_q <= ST_MUX_RD;
          else begin idx_q <= idx_q + 1'b1; st_q <= ST_TBL_WR; end
        end
        ST_MUX_RD:   begin mux_q <= bus_rdata; st_q <= ST_MUX_WR; end
        ST_MUX_WR:   st_q <= ST_RST_INIT;
        ST_RST_INIT: begin
          if (usb_q) rst_init <= 1'b0;
          st_q <= ST_SETTLE;
        end
        ST_SETTLE: if (tmr_expire) begin
          if (usb_q) st_q <= ST_REL_CMN;
          else begin done <= 1'b1; st_q <= ST_IDLE; end
        end
        ST_REL_CMN:  begin rst_cmn <= 1'b0; st_q <= ST_REL_LANE; end
        ST_REL_LANE: begin rst_lane <= 1'b0; tries_q <= '0; st_q <= ST_PLL_RD; end
        ST_PLL_RD: begin
          if (pll_ok)        begin tries_q <= '0; st_q <= ST_CDR_RD; end
          else if (poll_out) st_q <= ST_UNW_PHY;
          else begin tries_q <= tries_q + 1'b1; st_q <= ST_PLL_GAP; end
        end
        ST_PLL_GAP: if (tmr_expire) st_q <= ST_PLL_RD;
        ST_CDR_RD: begin
          if (cdr_ok)        begin done <= 1'b1; st_q <= ST_IDLE; end
          else if (poll_out) begin done <= 1'b1; cdr_warn <= 1'b1; st_q <= ST_IDLE; end
          else begin tries_q <= tries_q + 1'b1; st_q <= ST_CDR_GAP; end
        end
        ST_CDR_GAP: if (tmr_expire) st_q <= ST_CDR_RD;
        ST_UNW_PHY: begin
          rst_init <= 1'b1; rst_cmn <= 1'b1; rst_lane <= 1'b1;
          st_q <= ST_UNW_APB;
        end
        ST_UNW_APB: begin
          rst_pcsapb <= 1'b1; rst_pmaapb <= 1'b1;
          done <= 1'b1; error <= 1'b1;
          st_q <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/phy_bringup_chk.sv
module phy_bringup_chk #(
  parameter int SETTLE_CYC = 20
) (
  input logic clk,
  input logic rst_n,
  input logic usb_q,
  input logic lfps_en,
  input logic pma_pwr_en,
  input logic rst_init,
  input logic rst_cmn,
  input logic rst_lane,
  input logic rst_pcsapb,
  input logic rst_pmaapb,
  input logic bus_wr,
  input logic done,
  input logic error
);
  logic [15:0] since_init;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    since_init <= '0;
    else if (rst_init)             since_init <= '0;
    else if (since_init != 16'hFFFF) since_init <= since_init + 1'b1;
  end

  // R1
  lfps_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pma_pwr_en) && usb_q |-> $past(lfps_en));
  // R1
  lfps_usb_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lfps_en |-> usb_q);
  // R2
  pma_after_pwr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rst_pmaapb) |-> pma_pwr_en);
  // R2
  pcs_after_pma_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rst_pcsapb) |-> !rst_pmaapb);
  // R2
  wr_apb_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr |-> !rst_pmaapb && !rst_pcsapb);
  // R6
  init_usb_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rst_init) |-> usb_q);
  // R7
  cmn_settle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rst_cmn) |-> !rst_init && usb_q && (since_init >= 16'(SETTLE_CYC)));
  // R7
  lane_after_cmn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rst_lane) |-> !rst_cmn);
  // R10
  unwind_group_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_pcsapb) |-> rst_init && rst_cmn && rst_lane);
  // R10
  err_has_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    error |-> done);
endmodule

bind phy_bringup_seq phy_bringup_chk #(.SETTLE_CYC(SETTLE_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .usb_q(usb_q), .lfps_en(lfps_en),
  .pma_pwr_en(pma_pwr_en), .rst_init(rst_init), .rst_cmn(rst_cmn),
  .rst_lane(rst_lane), .rst_pcsapb(rst_pcsapb), .rst_pmaapb(rst_pmaapb),
  .bus_wr(bus_wr), .done(done), .error(error)
);

// File: tb/sim_phy_bringup_seq.sv
module sim_phy_bringup_seq;
  localparam int NI = 6, NR = 5, IB = 'h100, RB = 'h300, GAP = 3;
  localparam int MUXA = 'h0A0, DPRA = 'h0A4, PLLA = 'h0B0, C0A = 'h0C0, C2A = 'h0C8;
  localparam int SETTLE = 20, PGAP = 8, TRIES = 5;
  localparam int NT = NI + NR;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic mode_usb = 1'b0, mode_dp = 1'b0, flip = 1'b0;
  logic lfps_en, pma_pwr_en, rst_init, rst_cmn, rst_lane, rst_pcsapb, rst_pmaapb;
  logic bus_wr, bus_rd, bus_err, done, error, cdr_warn;
  logic [15:0] bus_addr, bus_wdata, bus_rdata;

  logic pll_good = 1'b1, cdr_good = 1'b1, fail_en = 1'b0;
  logic [15:0] fail_addr = '0;

  int checks = 0, errs = 0, cyc = 0;
  int nwr, npll, ncdr, pll_c0, pll_cl, cdr_a, pwr_rise, lfps_at_pwr;
  int wa [64], wd [64], wc [64];
  int asr [5], rel [5];
  logic [4:0] prv_r = 5'h1F;
  logic prv_pwr = 1'b0, prv_lfps = 1'b0;

  always #5ns clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  phy_bringup_seq #(
    .ADDR_W(16), .DATA_W(16), .N_INIT(NI), .N_REF(NR), .INIT_BASE(IB), .REF_BASE(RB),
    .TBL_GAP(GAP), .MUX_ADDR(MUXA), .DPRST_ADDR(DPRA), .PLL_ADDR(PLLA),
    .CDR0_ADDR(C0A), .CDR2_ADDR(C2A), .SETTLE_CYC(SETTLE), .POLL_GAP(PGAP),
    .POLL_TRIES(TRIES)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .mode_usb(mode_usb), .mode_dp(mode_dp),
    .flip(flip), .lfps_en(lfps_en), .pma_pwr_en(pma_pwr_en), .rst_init(rst_init),
    .rst_cmn(rst_cmn), .rst_lane(rst_lane), .rst_pcsapb(rst_pcsapb),
    .rst_pmaapb(rst_pmaapb), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_err(bus_err), .done(done),
    .error(error), .cdr_warn(cdr_warn)
  );

  // register file model seen by the sequencer
  always_comb begin
    bus_rdata = 16'h0000;
    if (bus_addr == 16'(MUXA))      bus_rdata = 16'hA5F0;
    else if (bus_addr == 16'(PLLA)) bus_rdata = pll_good ? 16'hFF03 : 16'hFFFD;
    else if (bus_addr == 16'(C0A) || bus_addr == 16'(C2A))
      bus_rdata = cdr_good ? 16'h0001 : 16'hFFFE;
  end
  assign bus_err = fail_en && bus_wr && (bus_addr == fail_addr);

  // event logger
  always @(negedge clk) begin
    logic [4:0] r;
    r = {rst_pmaapb, rst_pcsapb, rst_lane, rst_cmn, rst_init};
    if (bus_wr && nwr < 64) begin
      wa[nwr] = int'(bus_addr); wd[nwr] = int'(bus_wdata); wc[nwr] = cyc; nwr++;
    end
    if (bus_rd && bus_addr == 16'(PLLA)) begin
      npll++; if (npll == 1) pll_c0 = cyc; pll_cl = cyc;
    end
    if (bus_rd && (bus_addr == 16'(C0A) || bus_addr == 16'(C2A))) begin
      ncdr++; cdr_a = int'(bus_addr);
    end
    for (int i = 0; i < 5; i++) begin
      if (r[i] && !prv_r[i]) asr[i] = cyc;
      if (!r[i] && prv_r[i]) rel[i] = cyc;
    end
    if (pma_pwr_en && !prv_pwr) begin pwr_rise = cyc; lfps_at_pwr = int'(prv_lfps); end
    prv_r = r; prv_pwr = pma_pwr_en; prv_lfps = lfps_en;
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic run(input logic u, input logic d, input logic f);
    @(negedge clk);
    nwr = 0; npll = 0; ncdr = 0; pll_c0 = -1; pll_cl = -1; cdr_a = -1;
    pwr_rise = -1; lfps_at_pwr = -1;
    for (int i = 0; i < 5; i++) begin asr[i] = -1; rel[i] = -1; end
    mode_usb = u; mode_dp = d; flip = f; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done) @(negedge clk);
    @(negedge clk);
  endtask

  // expected table, built incrementally
  task automatic check_table(input int upto);
    int a, dat, ph;
    dat = 5; ph = 0; a = IB;
    for (int k = 0; k < upto; k++) begin
      if (k == NI) a = RB;
      chk($sformatf("R3 addr[%0d]", k), wa[k], a);
      chk($sformatf("R3 data[%0d]", k), wd[k], dat);
      if (k + 1 < upto)
        chk($sformatf("R4 gap[%0d]", k), wc[k+1] - wc[k], (ph == 3) ? 1 + GAP : 1);
      a += 4; dat = (dat + 37) & 8'hFF; ph = (ph == 4) ? 0 : ph + 1;
    end
  endtask

  task automatic t_reset();
    chk("R12 rst_init", int'(rst_init), 1);
    chk("R12 rst_cmn", int'(rst_cmn), 1);
    chk("R12 rst_lane", int'(rst_lane), 1);
    chk("R12 rst_pcsapb", int'(rst_pcsapb), 1);
    chk("R12 rst_pmaapb", int'(rst_pmaapb), 1);
    chk("R12 enables", int'({lfps_en, pma_pwr_en}), 0);
    chk("R12 flags", int'({done, error, cdr_warn}), 0);
    chk("R12 bus idle", int'({bus_wr, bus_rd}), 0);
  endtask

  task automatic t_usb_dp(input logic f);
    pll_good = 1; cdr_good = 1;
    run(1, 1, f);
    chk("R1 lfps before power", lfps_at_pwr, 1);
    chk("R2 power before pma apb", int'(pwr_rise < rel[4]), 1);
    chk("R2 pma before pcs", rel[3] - rel[4], 1);
    chk("R2 first write not before apb", int'(wc[0] >= rel[3]), 1);
    chk("R3 write count", nwr, NT + 2);
    check_table(NT);
    chk("R5 mux addr", wa[NT], MUXA);
    chk("R5 mux data", wd[NT], f ? 'hA503 : 'hA50C);
    chk("R6 dp init write", wa[NT+1] * 256 + wd[NT+1], DPRA * 256 + 1);
    chk("R6 init after mux", int'(rel[0] > wc[NT]), 1);
    chk("R7 settle", int'(rel[1] - rel[0] >= SETTLE), 1);
    chk("R7 lane after cmn", int'(rel[2] > rel[1]), 1);
    chk("R8 pll single read", npll, 1);
    chk("R9 cdr lane address", cdr_a, f ? C2A : C0A);
    chk("R9 flags", int'({done, error, cdr_warn}), 3'b100);
  endtask

  task automatic t_dp_only();
    run(0, 1, 0);
    chk("R1 lfps off in dp mode", int'(lfps_en), 0);
    chk("R3 write count dp", nwr, NT + 2);
    chk("R5 mux dp only", wd[NT], 'hA50F);
    chk("R6 dp write", wa[NT+1], DPRA);
    chk("R7 init held", int'(rst_init) + (rel[0] == -1 ? 1 : 0), 2);
    chk("R7 cmn lane held", int'({rst_cmn, rst_lane}), 3);
    chk("R7 no poll", npll + ncdr, 0);
    chk("R7 done", int'({done, error}), 2'b10);
  endtask

  task automatic t_usb_only();
    run(1, 0, 0);
    chk("R3 write count usb", nwr, NT + 1);
    check_table(NT);
    chk("R5 mux usb only", wd[NT], 'hA500);
    chk("R6 no dp write", int'(rel[0] > wc[NT]), 1);
    chk("R7 lane released", int'(rst_lane), 0);
  endtask

  task automatic t_pll_fail();
    pll_good = 0;
    run(1, 1, 0);
    pll_good = 1;
    chk("R8 pll reads", npll, TRIES);
    chk("R8 pll spacing", pll_cl - pll_c0, (TRIES - 1) * (PGAP + 1));
    chk("R10 no cdr poll", ncdr, 0);
    chk("R10 core group together", int'(asr[0] == asr[1] && asr[1] == asr[2]), 1);
    chk("R10 apb one later", asr[3] - asr[1], 1);
    chk("R10 apb pair", asr[4] - asr[3], 0);
    chk("R10 all held", int'({rst_init, rst_cmn, rst_lane, rst_pcsapb, rst_pmaapb}), 5'h1F);
    chk("R10 flags", int'({done, error}), 2'b11);
  endtask

  task automatic t_cdr_fail();
    cdr_good = 0;
    run(1, 1, 0);
    cdr_good = 1;
    chk("R9 cdr reads", ncdr, TRIES);
    chk("R9 flags warn", int'({done, error, cdr_warn}), 3'b101);
    chk("R9 resets stay released", int'({rst_init, rst_cmn, rst_lane, rst_pcsapb}), 0);
  endtask

  task automatic t_tbl_fail();
    fail_en = 1; fail_addr = 16'(IB + 16);
    run(1, 1, 0);
    fail_en = 0;
    chk("R11 writes stop", nwr, 5);
    check_table(5);
    chk("R11 apb reasserted", int'({rst_pcsapb, rst_pmaapb}), 3);
    chk("R11 apb after fail", int'(asr[3] > wc[4]), 1);
    chk("R11 core never released", int'(rel[0] == -1 && rel[1] == -1 && rel[2] == -1), 1);
    chk("R11 flags", int'({done, error}), 2'b11);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_usb_dp(0);
    t_usb_dp(1);
    t_dp_only();
    t_usb_only();
    t_pll_fail();
    t_cdr_fail();
    t_tbl_fail();
    t_usb_dp(0);
    $display("CHECKS %0d ERRORS %0d", checks, errs);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    checks++; errs++;
    $display("FAIL watchdog R12 act=0 exp=1");
    $display("CHECKS %0d ERRORS %0d", checks, errs);
    $finish;
  end
endmodule